// File: doc/BRIEF.md
# Port Status Indicator Flash Encoder

This block drives the pull-down of an open-drain status indicator from a 3-bit port status code. A powered port lights the indicator steadily. An open port, or one that shows a termination which must not be powered, leaves it dark. Detection and fault results are shown as bursts of flashes, and the number of flashes in a burst identifies the condition. All timing comes from one system clock. A prescaler produces a millisecond-style tick, and every interval is a parameter counted in ticks.

A mode input selects the drive style. When the logic supply is generated on chip, every lit interval is chopped by a low-duty PWM: about 6 % duty at about 28 kHz, which is roughly 2.2 µs of pull-down per period. This keeps dissipation low in the external indicator drive. With an external logic supply the PWM is bypassed and the pull-down is held for as long as the indicator is lit. A change of status code or mode restarts the sequence, so a burst is never shown in part.

Top module: `led_flash_encoder`

## Requirements
- R1: With status code 1 (port powered) and external-supply mode (`int_supply_i`=0), `led_pull_o` is 1 on every cycle.
- R2: Status codes 0 (open or non-powered termination), 6 and 7 keep `led_pull_o` at 0 in both modes.
- R3: Status code 2 (signature resistance too low) shows bursts of 1 flash. Status code 3 (signature resistance too high) shows bursts of 2 flashes.
- R4: Status code 4 (overload) shows bursts of 5 flashes. Status code 5 (power budget refused turn-on) shows bursts of 9 flashes.
- R5: Each flash lasts FLASH_TICKS ticks. Flashes in a burst start SPACING_TICKS apart. The next burst starts REPEAT_TICKS after the start of the last flash. One tick is TICK_DIV clock cycles.
- R6: In internal-supply mode (`int_supply_i`=1), a lit interval drives `led_pull_o`=1 only in the first PWM_ON cycles of each PWM_PERIOD-cycle frame. The frame phase is zero at the restart edge.
- R7: In external-supply mode, `led_pull_o` equals the lit state with no chopping.
- R8: A change of `port_state_i` or `int_supply_i` is captured at the next rising edge. That edge restarts the tick prescaler, the PWM phase and the burst at its first flash. `led_pull_o` reflects the new state from the following edge on.
- R9: While `rst_ni` is low, `led_pull_o` is 0 and the captured status is code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| port_state_i | input | 3 | Port status code |
| int_supply_i | input | 1 | 1 = internal logic supply (PWM chopping), 0 = external supply |
| led_pull_o | output | 1 | 1 = pull the indicator pin low |

## Verification
The output is a single register. Its value after edge j depends on the state after edge j-1, where edge 0 is the one that captures a new status or mode. The first flash therefore appears one edge after the capture, and the edge-0 sample still shows the previous setting. Tick boundaries fall every TICK_DIV edges from edge 0, and the PWM frame also starts at edge 0. The scoreboard queues one expected value per edge, from edge 0 onward, and samples two time units after each rising edge, so each expectation is compared against the register after exactly that edge.

// File: rtl/led_flash_pkg.sv
package led_flash_pkg;
  localparam int unsigned ST_W  = 3;
  localparam int unsigned CNT_W = 4;

  localparam logic [ST_W-1:0] ST_DARK      = 3'd0;
  localparam logic [ST_W-1:0] ST_POWERED   = 3'd1;
  localparam logic [ST_W-1:0] ST_SIG_LOW   = 3'd2;
  localparam logic [ST_W-1:0] ST_SIG_HIGH  = 3'd3;
  localparam logic [ST_W-1:0] ST_OVERLOAD  = 3'd4;
  localparam logic [ST_W-1:0] ST_NO_BUDGET = 3'd5;

  function automatic logic [CNT_W-1:0] flash_count(input logic [ST_W-1:0] st);
    case (st)
      ST_SIG_LOW:   flash_count = 4'd1;
      ST_SIG_HIGH:  flash_count = 4'd2;
      ST_OVERLOAD:  flash_count = 4'd5;
      ST_NO_BUDGET: flash_count = 4'd9;
      default:      flash_count = 4'd0;
    endcase
  endfunction
endpackage

// File: rtl/led_tick_gen.sv
module led_tick_gen #(
  parameter int unsigned DIV = 10000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;

  generate
    if (DIV > 1) begin : g_div
      localparam logic [CW-1:0] LAST = CW'(DIV - 1);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                        cnt_q <= '0;
        else if (clear_i || cnt_q == LAST)  cnt_q <= '0;
        else                                cnt_q <= cnt_q + 1'b1;
      end

      assign tick_o = (cnt_q == LAST);

      // ticks are isolated single-cycle pulses
      p_tick_gap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);
      // a restart holds the tick off for at least one cycle
      p_tick_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clear_i |=> !tick_o);
    end else begin : g_pass
      logic unused_w;
      assign unused_w = clear_i ^ clk_i ^ rst_ni;
      assign tick_o   = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/led_pwm_gen.sv
module led_pwm_gen #(
  parameter int unsigned PERIOD = 357,
  parameter int unsigned ON     = 22
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  output logic pwm_o
);
  localparam int unsigned  CW   = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);
  localparam logic [CW:0]   ON_V = (CW+1)'(ON);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (clear_i || cnt_q == LAST)  cnt_q <= '0;
    else                                cnt_q <= cnt_q + 1'b1;
  end

  assign pwm_o = ({1'b0, cnt_q} < ON_V);

  // the frame opens with its active phase right after a restart
  p_pwm_phase_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (pwm_o == (ON > 0)));
endmodule

// File: rtl/led_burst_seq.sv
module led_burst_seq
  import led_flash_pkg::*;
#(
  parameter int unsigned FLASH   = 75,
  parameter int unsigned SPACING = 300,
  parameter int unsigned REPEAT  = 1200
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] count_i,
  output logic             flash_o
);
  localparam int unsigned   MAXL    = (SPACING > REPEAT) ? SPACING : REPEAT;
  localparam int unsigned   SW      = $clog2(MAXL + 1);
  localparam logic [SW-1:0] SPC_END = SW'(SPACING - 1);
  localparam logic [SW-1:0] REP_END = SW'(REPEAT - 1);
  localparam logic [SW-1:0] FL_V    = SW'(FLASH);

  logic [SW-1:0]    slot_q;
  logic [CNT_W-1:0] idx_q;
  logic             last_slot;
  logic [SW-1:0]    slot_end;

  // the last flash of a burst carries the long repeat gap
  assign last_slot = ((idx_q + 4'd1) >= count_i);
  assign slot_end  = last_slot ? REP_END : SPC_END;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q <= '0;
      idx_q  <= '0;
    end else if (restart_i) begin
      slot_q <= '0;
      idx_q  <= '0;
    end else if (tick_i) begin
      if (slot_q == slot_end) begin
        slot_q <= '0;
        idx_q  <= last_slot ? '0 : idx_q + 1'b1;
      end else begin
        slot_q <= slot_q + 1'b1;
      end
    end
  end

  assign flash_o = (count_i != '0) && (slot_q < FL_V);

  p_idx_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_i != '0) |-> (idx_q < count_i));
  p_restart_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (slot_q == '0 && idx_q == '0));
endmodule

// File: rtl/led_flash_encoder.sv
module led_flash_encoder
  import led_flash_pkg::*;
#(
  parameter int unsigned TICK_DIV      = 10000,
  parameter int unsigned FLASH_TICKS   = 75,
  parameter int unsigned SPACING_TICKS = 300,
  parameter int unsigned REPEAT_TICKS  = 1200,
  parameter int unsigned PWM_PERIOD    = 357,
  parameter int unsigned PWM_ON        = 22
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [ST_W-1:0] port_state_i,
  input  logic            int_supply_i,
  output logic            led_pull_o
);
  logic [ST_W-1:0]  state_q;
  logic             int_q;
  logic             led_q;
  logic             restart;
  logic             tick;
  logic             pwm;
  logic             flash;
  logic             lit;
  logic [CNT_W-1:0] count;

  assign restart = (port_state_i != state_q) || (int_supply_i != int_q);
  assign count   = flash_count(state_q);

  led_tick_gen #(.DIV(TICK_DIV)) i_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(restart), .tick_o(tick)
  );

  led_pwm_gen #(.PERIOD(PWM_PERIOD), .ON(PWM_ON)) i_pwm (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(restart), .pwm_o(pwm)
  );

  led_burst_seq #(
    .FLASH(FLASH_TICKS), .SPACING(SPACING_TICKS), .REPEAT(REPEAT_TICKS)
  ) i_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .restart_i(restart), .tick_i(tick),
    .count_i(count), .flash_o(flash)
  );

  assign lit = (state_q == ST_POWERED) || flash;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_DARK;
      int_q   <= 1'b0;
      led_q   <= 1'b0;
    end else begin
      state_q <= port_state_i;
      int_q   <= int_supply_i;
      led_q   <= lit && (pwm || !int_q);
    end
  end

  assign led_pull_o = led_q;

  p_powered_on_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_POWERED && !int_q) |=> led_pull_o);
  p_dark_off_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_POWERED && count == '0) |=> !led_pull_o);
endmodule

// File: tb/test_led_flash_encoder.sv
module test_led_flash_encoder;
  localparam int CLK_PERIOD = 10;
  localparam int D = 2;
  localparam int F = 3;
  localparam int S = 5;
  localparam int R = 20;
  localparam int P = 7;
  localparam int ON = 2;

  typedef struct {
    logic  exp;
    string tag;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] st = 3'd0;
  logic md = 1'b0;
  logic led;

  item_t q[$];
  int total = 0;
  int bad = 0;
  logic [2:0] prev_st = 3'd0;
  logic prev_md = 1'b0;
  int prev_n = 1;
  string prev_tag = "R9";

  always #(CLK_PERIOD/2) clk = ~clk;

  led_flash_encoder #(
    .TICK_DIV(D), .FLASH_TICKS(F), .SPACING_TICKS(S), .REPEAT_TICKS(R),
    .PWM_PERIOD(P), .PWM_ON(ON)
  ) i_led_flash_encoder (
    .clk_i(clk), .rst_ni(rst_n), .port_state_i(st), .int_supply_i(md),
    .led_pull_o(led)
  );

  function automatic int nflash(logic [2:0] s);
    case (s)
      3'd2: return 1;
      3'd3: return 2;
      3'd4: return 5;
      3'd5: return 9;
      default: return 0;
    endcase
  endfunction

  // output after edge j, edge 0 being the capture edge
  function automatic logic model_out(logic [2:0] s, logic m, int j);
    int k, n, len, pos;
    logic lit, pw;
    if (j < 1) return 1'b0;
    k = j - 1;
    n = nflash(s);
    if (s == 3'd1) lit = 1'b1;
    else if (n == 0) lit = 1'b0;
    else begin
      len = (n - 1) * S + R;
      pos = (k / D) % len;
      lit = ((pos / S) < n) && ((pos % S) < F);
    end
    pw = ((k % P) < ON);
    return lit && (m ? pw : 1'b1);
  endfunction

  task automatic check(logic act, logic exp, string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: led_pull_o=%0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic report();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // driver: push one expectation per edge, then hold the inputs
  task automatic apply(logic [2:0] s, logic m, int n, string tag);
    item_t it;
    @(negedge clk);
    st = s;
    md = m;
    it.exp = model_out(prev_st, prev_md, prev_n);
    it.tag = prev_tag;
    q.push_back(it);
    for (int j = 1; j < n; j++) begin
      it.exp = model_out(s, m, j);
      it.tag = tag;
      q.push_back(it);
    end
    prev_st = s;
    prev_md = m;
    prev_n = n;
    prev_tag = tag;
    repeat (n - 1) @(negedge clk);
  endtask

  // monitor
  initial begin
    item_t it;
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        it = q.pop_front();
        check(led, it.exp, it.tag);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: run did not complete");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(led, 1'b0, "R9");   // held in reset
    rst_n = 1'b1;
    @(negedge clk);
    check(led, 1'b0, "R9");
    apply(3'd1, 1'b0, 40, "R1");     // steady on, external supply
    apply(3'd2, 1'b0, 90, "R5");     // single flash, repeat spacing
    apply(3'd3, 1'b0, 100, "R3");    // two flashes
    apply(3'd4, 1'b0, 170, "R4");    // five flashes
    apply(3'd5, 1'b0, 250, "R4");    // nine flashes
    apply(3'd5, 1'b1, 150, "R6");    // mode change alone restarts, chopped
    apply(3'd1, 1'b1, 40, "R6");     // steady on, chopped
    apply(3'd3, 1'b1, 60, "R6");
    apply(3'd3, 1'b0, 60, "R7");     // unchopped flashes
    apply(3'd4, 1'b0, 13, "R8");     // cut mid-burst
    apply(3'd2, 1'b0, 60, "R8");     // new code starts at its first flash
    apply(3'd4, 1'b0, 5, "R8");      // cut inside the first flash
    apply(3'd0, 1'b0, 30, "R2");
    apply(3'd6, 1'b0, 20, "R2");
    apply(3'd7, 1'b1, 20, "R2");
    apply(3'd0, 1'b1, 20, "R2");
    repeat (2) @(negedge clk);
    report();
  end
endmodule